// File: doc/BRIEF.md
# Discrete State-Space Controller Sequencer

This block is a fixed-point linear controller that runs one step per sample. On each sample strobe it evaluates the state update x(k+1) = A·x(k) + B·u(k) and the output equation y(k) = C·x(k) + D·u(k). Two instances of one matrix-equation unit do this work side by side, and both read the same registered state x(k). Each unit walks through the rows of its matrices one per clock. Inside a row, every column product is formed in parallel. A sample therefore costs max(N, Q) multiply steps.

A small cycle timer does the sequencing. It latches the input vector and starts both units when the strobe arrives. It then waits until both units report completion. In a separate commit phase it writes the new state and presents the new output vector. A strobe that arrives before a sample has committed is dropped, and it sets a sticky overrun flag.

The coefficient matrices are fixed at elaboration from the functions in the package. The block has no interface for loading them.

Top module: `ssc_controller`

## Requirements
- R1: After reset the output vector is all zero, `y_valid_o` is 0, `overrun_o` is 0, and the internal state vector is zero.
- R2: Output element r is sat(floor((Σc C[r][c]·x[c] + Σc D[r][c]·u[c]) / 256)), computed from x(k) and the latched u(k). C[r][c] is 256 when c = r mod N and 0 otherwise. D[r][c] is 64 when c = r mod P and 0 otherwise.
- R3: On each sample the state becomes x[r] = sat(floor((Σc A[r][c]·x[c] + Σc B[r][c]·u[c]) / 256)). A[r][r] = 128, A[r][r+1] = 32, and every other A entry is 0. B[r][c] is 256 when c = r mod P and 0 otherwise. The new state is used by the next sample.
- R4: The outputs change exactly max(N,Q)+2 clock edges after the edge that samples the strobe high. The edge that samples the strobe counts as edge 0. Before that edge the outputs hold their previous values.
- R5: The input vector is captured on the strobe edge. Changes to `u_i` during the rest of the sample have no effect on the result.
- R6: A strobe seen while a sample is still running or committing is ignored. It sets `overrun_o`, which stays set until reset. A strobe seen while idle never sets `overrun_o`.
- R7: `y_valid_o` rises at the first commit and stays high until reset.
- R8: Every state and output element saturates to the signed 16-bit range [-32768, 32767].
- R9: Both matrix units start on the same edge. The commit happens only once both have finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| sample_i | input | 1 | Sample strobe, one cycle high |
| u_i | input | P*16 | Input vector. Element c is at bits [16c+15:16c], two's complement |
| y_o | output | Q*16 | Output vector. Element r is at bits [16r+15:16r] |
| y_valid_o | output | 1 | High once the first sample has committed |
| overrun_o | output | 1 | Sticky flag for a strobe that arrived during a running sample |

## Verification
Several properties are checked on every cycle by the assertions. A commit never happens unless both units are done, and a unit is never restarted while it is busy. The latched input holds steady for the whole sample, and the valid and overrun flags never fall. The bench scenarios cover what those properties cannot. They check the numeric results against an independent model across chained samples, the exact latency edge, and that a mid-sample change of `u_i` or an extra strobe leaves the result untouched. They also check that saturation clamps at both ends of the range.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

   // Fractional bits of every coefficient (value 256 represents 1.0)
   localparam int COEF_FRAC = 8;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_RUN    = 2'd1,
      PH_COMMIT = 2'd2
   } phase_e;

   // State transition matrix: 0.5 on the diagonal, 0.125 just above it
   function automatic int coef_a(int r, int c);
      if (r == c)     return 128;
      if (c == r + 1) return 32;
      return 0;
   endfunction

   // Input-to-state matrix
   function automatic int coef_b(int r, int c, int p);
      return (c == r % p) ? 256 : 0;
   endfunction

   // State-to-output matrix
   function automatic int coef_c(int r, int c, int n);
      return (c == r % n) ? 256 : 0;
   endfunction

   // Feed-through matrix
   function automatic int coef_d(int r, int c, int p);
      return (c == r % p) ? 64 : 0;
   endfunction

endpackage

// File: rtl/ssc_mat_unit.sv
// Matrix-equation unit: res = M*a + N*b, one row per clock, saturated.
module ssc_mat_unit #(
   parameter int ROWS = 3,
   parameter int NA   = 3,
   parameter int NB   = 2,
   parameter int DW   = 16,
   parameter int CW   = 16,
   parameter int AW   = 32,
   parameter int MODE = 0   // 0: state update (A,B)  1: output (C,D)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic [NA*DW-1:0]   a_i,
   input  logic [NB*DW-1:0]   b_i,
   output logic [ROWS*DW-1:0] res_o,
   output logic               done_o
);
   localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam int PW = CW + DW;
   localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (DW - 1)) - AW'(1);
   localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

   if (ROWS < 1 || NA < 1 || NB < 1) begin : g_bad_dims
      $error("ssc_mat_unit: dimensions must be at least 1");
   end
   if (AW < PW) begin : g_bad_acc
      $error("ssc_mat_unit: accumulator narrower than a product");
   end
   if (MODE != 0 && MODE != 1) begin : g_bad_mode
      $error("ssc_mat_unit: MODE must be 0 or 1");
   end

   logic                busy_q;
   logic                done_q;
   logic [RW-1:0]       row_q;
   logic [DW-1:0]       res_q [ROWS];
   logic signed [CW-1:0] cm [NA];
   logic signed [CW-1:0] cn [NB];

   // Coefficient row selection: the variant is fixed by MODE
   if (MODE == 0) begin : g_state_coef
      always_comb begin
         for (int c = 0; c < NA; c++) cm[c] = CW'(ssc_pkg::coef_a(int'(row_q), c));
         for (int c = 0; c < NB; c++) cn[c] = CW'(ssc_pkg::coef_b(int'(row_q), c, NB));
      end
   end else begin : g_out_coef
      always_comb begin
         for (int c = 0; c < NA; c++) cm[c] = CW'(ssc_pkg::coef_c(int'(row_q), c, NA));
         for (int c = 0; c < NB; c++) cn[c] = CW'(ssc_pkg::coef_d(int'(row_q), c, NB));
      end
   end

   // One row: all column products in parallel, then scale and clamp
   logic signed [AW-1:0] acc;
   logic signed [AW-1:0] shd;
   logic signed [PW-1:0] prod;
   logic [DW-1:0]        satv;

   always_comb begin
      acc  = '0;
      prod = '0;
      for (int c = 0; c < NA; c++) begin
         prod = cm[c] * $signed(a_i[c*DW +: DW]);
         acc  = acc + AW'(prod);
      end
      for (int c = 0; c < NB; c++) begin
         prod = cn[c] * $signed(b_i[c*DW +: DW]);
         acc  = acc + AW'(prod);
      end
      shd = acc >>> ssc_pkg::COEF_FRAC;
      if (shd > MAXV)      satv = MAXV[DW-1:0];
      else if (shd < MINV) satv = MINV[DW-1:0];
      else                 satv = shd[DW-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         row_q  <= '0;
         for (int r = 0; r < ROWS; r++) res_q[r] <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         done_q <= 1'b0;
         row_q  <= '0;
      end else if (busy_q) begin
         res_q[row_q] <= satv;
         if (row_q == RW'(ROWS - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            row_q <= row_q + RW'(1);
         end
      end
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_pack
      assign res_o[r*DW +: DW] = res_q[r];
   end
   assign done_o = done_q;

   AST_ROW_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |-> (int'(row_q) < ROWS)); // R4
   AST_NO_RESTART_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |-> !busy_q); // R6
   AST_DONE_FROM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_q) |-> $past(busy_q)); // R4

endmodule

// File: rtl/ssc_timer.sv
// Cycle timer: starts both units, waits for both, then commits.
module ssc_timer
   import ssc_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sample_i,
   input  logic st_done_i,
   input  logic out_done_i,
   output logic start_o,
   output logic commit_o,
   output logic busy_o,
   output logic overrun_o
);
   phase_e ph_q, ph_d;
   logic   ovr_q;

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE:   if (sample_i) ph_d = PH_RUN;
         PH_RUN:    if (st_done_i && out_done_i) ph_d = PH_COMMIT;
         PH_COMMIT: ph_d = PH_IDLE;
         default:   ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q  <= PH_IDLE;
         ovr_q <= 1'b0;
      end else begin
         ph_q <= ph_d;
         if (sample_i && ph_q != PH_IDLE) ovr_q <= 1'b1;
      end
   end

   assign start_o   = sample_i && (ph_q == PH_IDLE);
   assign commit_o  = (ph_q == PH_COMMIT);
   assign busy_o    = (ph_q != PH_IDLE);
   assign overrun_o = ovr_q;

   AST_COMMIT_BOTH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_o |-> (st_done_i && out_done_i)); // R9
   AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovr_q |=> ovr_q); // R6
   AST_IDLE_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ovr_q && ph_q == PH_IDLE) |=> !ovr_q); // R6

endmodule

// File: rtl/ssc_controller.sv
// Fixed-point discrete state-space controller, one step per sample strobe.
module ssc_controller #(
   parameter int N  = 3,
   parameter int P  = 2,
   parameter int Q  = 2,
   parameter int DW = 16,
   parameter int AW = 32
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            sample_i,
   input  logic [P*DW-1:0] u_i,
   output logic [Q*DW-1:0] y_o,
   output logic            y_valid_o,
   output logic            overrun_o
);
   if (N < 1 || P < 1 || Q < 1) begin : g_bad_dims
      $error("ssc_controller: N, P and Q must be at least 1");
   end
   if (DW < 2 || AW < 2 * DW) begin : g_bad_width
      $error("ssc_controller: AW must hold a full product");
   end

   logic [N*DW-1:0] x_q;
   logic [N*DW-1:0] x_next;
   logic [Q*DW-1:0] y_q;
   logic [Q*DW-1:0] y_next;
   logic [P*DW-1:0] u_q;
   logic            valid_q;
   logic            start, commit, tmr_busy, st_done, out_done;

   ssc_timer u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sample_i   (sample_i),
      .st_done_i  (st_done),
      .out_done_i (out_done),
      .start_o    (start),
      .commit_o   (commit),
      .busy_o     (tmr_busy),
      .overrun_o  (overrun_o)
   );

   ssc_mat_unit #(.ROWS(N), .NA(N), .NB(P), .DW(DW), .CW(DW), .AW(AW), .MODE(0)) u_state (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .a_i     (x_q),
      .b_i     (u_q),
      .res_o   (x_next),
      .done_o  (st_done)
   );

   ssc_mat_unit #(.ROWS(Q), .NA(N), .NB(P), .DW(DW), .CW(DW), .AW(AW), .MODE(1)) u_output (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .a_i     (x_q),
      .b_i     (u_q),
      .res_o   (y_next),
      .done_o  (out_done)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         u_q     <= '0;
         x_q     <= '0;
         y_q     <= '0;
         valid_q <= 1'b0;
      end else begin
         if (start) u_q <= u_i;
         if (commit) begin
            x_q     <= x_next;
            y_q     <= y_next;
            valid_q <= 1'b1;
         end
      end
   end

   assign y_o       = y_q;
   assign y_valid_o = valid_q;

   AST_VALID_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |=> valid_q); // R7
   AST_INPUT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmr_busy |=> $stable(u_q)); // R5
   AST_STATE_HELD_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tmr_busy && !commit) |=> $stable(x_q)); // R9

endmodule

// File: tb/ssc_controller_tb.sv
module ssc_controller_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 3;
   localparam int P  = 2;
   localparam int Q  = 2;
   localparam int DW = 16;
   localparam int M  = (N > Q) ? N : Q;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sample = 1'b0;
   logic [P*DW-1:0] u = '0;
   logic [Q*DW-1:0] y;
   logic            y_valid;
   logic            overrun;

   int  checks = 0;
   int  fails  = 0;
   bit  ended  = 1'b0;
   int  xm [N];
   int  ym [Q];

   always #(CLK_PERIOD / 2) clk = ~clk;

   ssc_controller #(.N(N), .P(P), .Q(Q), .DW(DW), .AW(32)) dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .sample_i  (sample),
      .u_i       (u),
      .y_o       (y),
      .y_valid_o (y_valid),
      .overrun_o (overrun)
   );

   function automatic int sat16(longint v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return int'(v);
   endfunction

   // Independent model of one controller step (R2, R3)
   task automatic model_step(int u0, int u1);
      int     un [P];
      int     xn [N];
      longint acc;
      un[0] = u0;
      un[1] = u1;
      for (int r = 0; r < Q; r++) begin
         acc   = 256 * longint'(xm[r % N]) + 64 * longint'(un[r % P]);
         ym[r] = sat16(acc >>> 8);
      end
      for (int r = 0; r < N; r++) begin
         acc = 128 * longint'(xm[r]) + 256 * longint'(un[r % P]);
         if (r + 1 < N) acc = acc + 32 * longint'(xm[r + 1]);
         xn[r] = sat16(acc >>> 8);
      end
      for (int r = 0; r < N; r++) xm[r] = xn[r];
   endtask

   task automatic check(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int y_elem(int r);
      return int'($signed(y[r*DW +: DW]));
   endfunction

   task automatic check_y(string req, string what);
      for (int r = 0; r < Q; r++) check(req, what, y_elem(r), ym[r]);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // One sample; optional mid-sample input change and extra strobe
   task automatic run_sample(int u0, int u1, bit change_u, bit extra_strobe);
      int old_y [Q];
      for (int r = 0; r < Q; r++) old_y[r] = ym[r];
      @(negedge clk);
      u      = {16'(u1), 16'(u0)};
      sample = 1'b1;
      @(negedge clk);                 // after edge 0
      sample = 1'b0;
      if (change_u) u = {16'(u0 ^ 16'h5a5a), 16'(u1 + 1000)};
      if (extra_strobe) begin
         @(negedge clk);              // after edge 1
         sample = 1'b1;
         @(negedge clk);              // after edge 2
         sample = 1'b0;
         repeat (M - 1) @(negedge clk);
      end else begin
         repeat (M + 1) @(negedge clk);
      end
      // after edge M+1: outputs must still hold the previous values
      for (int r = 0; r < Q; r++) check("R4", "output before commit edge", y_elem(r), old_y[r]);
      model_step(u0, u1);
      @(negedge clk);                 // after edge M+2
      check_y("R2", "output vector");
      check("R7", "valid after commit", y_valid, 1);
   endtask

   task automatic t_reset();
      check("R1", "y0 after reset", y_elem(0), 0);
      check("R1", "y1 after reset", y_elem(1), 0);
      check("R1", "valid after reset", y_valid, 0);
      check("R1", "overrun after reset", overrun, 0);
   endtask

   task automatic t_basic();
      run_sample(256, -512, 1'b0, 1'b0);
      // R9: both units started together; both rows landed on the same edge
      check("R9", "row0 and row1 committed together", y_elem(1), ym[1]);
      check("R6", "no overrun when idle strobe", overrun, 0);
   endtask

   task automatic t_chain();
      // R3: the committed state feeds the next sample
      run_sample(256, -512, 1'b0, 1'b0);
      run_sample(-1000, 300, 1'b0, 1'b0);
      run_sample(0, 0, 1'b0, 1'b0);
      check("R3", "state carried into y0", y_elem(0), ym[0]);
   endtask

   task automatic t_input_change();
      run_sample(1234, -77, 1'b1, 1'b0);
      check("R5", "late input change ignored", y_elem(0), ym[0]);
      run_sample(0, 0, 1'b0, 1'b0);
      check("R5", "state from latched input", y_elem(1), ym[1]);
   endtask

   task automatic t_overrun();
      run_sample(500, 400, 1'b0, 1'b1);
      check("R6", "overrun set by early strobe", overrun, 1);
      repeat (M + 4) @(negedge clk);
      check_y("R6", "no extra commit from early strobe");
      run_sample(0, 0, 1'b0, 1'b0);
      check("R6", "overrun stays set", overrun, 1);
   endtask

   task automatic t_saturate();
      for (int k = 0; k < 4; k++) run_sample(32767, 32767, 1'b0, 1'b0);
      check("R8", "positive clamp y0", y_elem(0), 32767);
      for (int k = 0; k < 5; k++) run_sample(-32768, -32768, 1'b0, 1'b0);
      check("R8", "negative clamp y0", y_elem(0), -32768);
      check("R8", "negative clamp y1", y_elem(1), -32768);
   endtask

   initial begin
      repeat (CLK_PERIOD * 5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int r = 0; r < N; r++) xm[r] = 0;
      for (int r = 0; r < Q; r++) ym[r] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_chain();
      t_input_change();
      t_overrun();
      t_saturate();
      finish_run();
   end

endmodule